// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by fetching two entries from page tables held in memory. Pages are 8 KB. The top eight address bits select a slot in a 256-entry directory. The directory entry names the page that holds a 2048-entry page table, and the next eleven address bits select the entry within that table. The low thirteen bits are the offset within the page and are passed through unchanged. There is no intermediate table level, so every walk that reaches the second level costs exactly two memory reads.

A requester presents a virtual address together with the directory base. The walker takes it when idle and issues its reads one at a time on a valid/ready read port that has a separate single-cycle response strobe. It then holds either a physical address or a fault on its result port until the requester acknowledges it. Bit 0 of every entry is a present flag. A clear flag at either level ends the walk with a fault.

Top module: `pgwalk_top`

## Requirements
- R1: While reset is held and on the first cycle after it is released, `req_ready` is 1 and both `resp_valid` and `mem_rd_valid` are 0.
- R2: The first read of a walk targets `dir_base + 4 * vaddr[31:24]`.
- R3: The second read targets `{dir_entry[31:13], 13'b0} + 4 * vaddr[23:13]`. Bits 12:0 of the directory entry play no part in this address.
- R4: A successful walk returns `resp_paddr = {table_entry[31:13], vaddr[12:0]}` with `resp_fault = 0`.
- R5: If bit 0 of the directory entry is 0, the walk makes no second read and returns `resp_fault = 1` with `resp_paddr = 0`.
- R6: If bit 0 of the table entry is 0, the walk returns `resp_fault = 1` with `resp_paddr = 0`.
- R7: A request is taken only while `req_ready` is 1, which happens only when no walk is in progress and no result is pending. `req_valid` asserted at any other time has no effect.
- R8: Once raised, `mem_rd_valid` stays high and `mem_rd_addr` stays unchanged until `mem_rd_ready` is seen.
- R9: Once raised, `resp_valid` stays high and `resp_paddr` and `resp_fault` stay unchanged until `resp_ready` is seen.
- R10: At most one read is outstanding. No new read is requested until the response to the previous one has arrived.
- R11: `dir_base` is sampled in the cycle a request is taken. Later changes to it do not affect that walk.
- R12: A walk that ends without a fault makes exactly two reads.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and able to take a request |
| req_vaddr | input | 32 | Virtual address to translate |
| dir_base | input | 32 | Byte address of the directory |
| mem_rd_valid | output | 1 | Read request to memory |
| mem_rd_ready | input | 1 | Memory takes the read request |
| mem_rd_addr | output | 32 | Byte address of the entry to read |
| mem_rsp_valid | input | 1 | Single-cycle strobe: read data present |
| mem_rsp_data | input | 32 | Entry read from memory |
| resp_valid | output | 1 | Result present |
| resp_ready | input | 1 | Requester takes the result |
| resp_paddr | output | 32 | Physical address, zero on a fault |
| resp_fault | output | 1 | Walk ended on a non-present entry |

## Verification
The bound checker checks the following on every cycle: the handshake stability rules on both the read port and the result port, the single-outstanding-read limit, exclusion of a new request while busy, the zero address on faults, offset pass-through, and the read count of a completed walk. Whether the right table entries were fetched, which means the address arithmetic at both levels, the masking of low entry bits, and the sampling of the base at acceptance, can only be shown by the bench's scenarios. The bench does this by comparing results against a memory model filled with chosen and pseudo-random entries, under varied read stalls, response latencies and result back-pressure.

// File: rtl/pgwalk_pkg.sv
`timescale 1ns/1ps
package pgwalk_pkg;

    typedef enum logic [2:0] {
        WK_IDLE,
        WK_DIR_REQ,
        WK_DIR_WAIT,
        WK_TBL_REQ,
        WK_TBL_WAIT,
        WK_DONE
    } walk_state_e;

endpackage

// File: rtl/pgwalk_entry_dec.sv
`timescale 1ns/1ps
module pgwalk_entry_dec #(
    parameter int W        = 32,
    parameter int OFF_W    = 13,
    parameter int PRES_BIT = 0
) (
    input  logic [W-1:0]       entry,
    output logic               present,
    output logic [W-OFF_W-1:0] frame
);
    localparam int FRM_W = W - OFF_W;

    logic unused_low_bits;

    assign present         = entry[PRES_BIT];
    assign frame           = entry[W-1 -: FRM_W];
    assign unused_low_bits = ^entry[OFF_W-1:0];
endmodule

// File: rtl/pgwalk_addr_gen.sv
`timescale 1ns/1ps
module pgwalk_addr_gen #(
    parameter int W        = 32,
    parameter int VA_W     = 32,
    parameter int OFF_W    = 13,
    parameter int TBL_W    = 11,
    parameter int ENT_LOG2 = 2
) (
    input  logic [VA_W-1:0]    vaddr,
    input  logic [W-1:0]       dir_base,
    input  logic [W-OFF_W-1:0] tbl_frame,
    output logic [W-1:0]       dir_addr,
    output logic [W-1:0]       tbl_addr
);
    localparam int DIR_W  = VA_W - OFF_W - TBL_W;
    localparam int LEVELS = 2;

    logic [LEVELS-1:0][W-1:0] lvl_base;
    logic [LEVELS-1:0][W-1:0] lvl_index;
    logic [LEVELS-1:0][W-1:0] lvl_addr;
    logic                     unused_va;

    assign lvl_base[0]  = dir_base;
    assign lvl_base[1]  = {tbl_frame, {OFF_W{1'b0}}};
    assign lvl_index[0] = W'(vaddr[VA_W-1 -: DIR_W]);
    assign lvl_index[1] = W'(vaddr[OFF_W +: TBL_W]);
    assign unused_va    = ^vaddr[OFF_W-1:0];

    for (genvar lv = 0; lv < LEVELS; lv++) begin : g_level
        assign lvl_addr[lv] = lvl_base[lv] + (lvl_index[lv] << ENT_LOG2);
    end

    assign dir_addr = lvl_addr[0];
    assign tbl_addr = lvl_addr[1];
endmodule

// File: rtl/pgwalk_fsm.sv
`timescale 1ns/1ps
module pgwalk_fsm
    import pgwalk_pkg::*;
#(
    parameter int W     = 32,
    parameter int VA_W  = 32,
    parameter int OFF_W = 13
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [VA_W-1:0]    req_vaddr,
    input  logic [W-1:0]       dir_base,
    input  logic               mem_rd_ready,
    input  logic               mem_rsp_valid,
    input  logic               ent_present,
    input  logic [W-OFF_W-1:0] ent_frame,
    input  logic               resp_ready,
    output logic               req_ready,
    output logic               mem_rd_valid,
    output logic               rd_second,
    output logic               resp_valid,
    output logic               fault_q,
    output logic [VA_W-1:0]    va_q,
    output logic [W-1:0]       dbase_q,
    output logic [W-OFF_W-1:0] frame_q
);
    localparam int FRM_W = W - OFF_W;

    typedef struct packed {
        walk_state_e      st;
        logic [VA_W-1:0]  va;
        logic [W-1:0]     dbase;
        logic [FRM_W-1:0] frame;
        logic             fault;
    } walk_regs_t;

    walk_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        case (r_q.st)
            WK_IDLE: begin
                if (req_valid) begin
                    r_d.st    = WK_DIR_REQ;
                    r_d.va    = req_vaddr;
                    r_d.dbase = dir_base;
                    r_d.frame = '0;
                    r_d.fault = 1'b0;
                end
            end
            WK_DIR_REQ: begin
                if (mem_rd_ready) r_d.st = WK_DIR_WAIT;
            end
            WK_DIR_WAIT: begin
                if (mem_rsp_valid) begin
                    if (ent_present) begin
                        r_d.frame = ent_frame;
                        r_d.st    = WK_TBL_REQ;
                    end else begin
                        r_d.frame = '0;
                        r_d.fault = 1'b1;
                        r_d.st    = WK_DONE;
                    end
                end
            end
            WK_TBL_REQ: begin
                if (mem_rd_ready) r_d.st = WK_TBL_WAIT;
            end
            WK_TBL_WAIT: begin
                if (mem_rsp_valid) begin
                    r_d.st = WK_DONE;
                    if (ent_present) begin
                        r_d.frame = ent_frame;
                    end else begin
                        r_d.frame = '0;
                        r_d.fault = 1'b1;
                    end
                end
            end
            WK_DONE: begin
                if (resp_ready) r_d.st = WK_IDLE;
            end
            default: r_d.st = WK_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{st: WK_IDLE, va: '0, dbase: '0, frame: '0, fault: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign req_ready    = (r_q.st == WK_IDLE);
    assign mem_rd_valid = (r_q.st == WK_DIR_REQ) || (r_q.st == WK_TBL_REQ);
    assign rd_second    = (r_q.st == WK_TBL_REQ);
    assign resp_valid   = (r_q.st == WK_DONE);
    assign fault_q      = r_q.fault;
    assign va_q         = r_q.va;
    assign dbase_q      = r_q.dbase;
    assign frame_q      = r_q.frame;
endmodule

// File: rtl/pgwalk_top.sv
`timescale 1ns/1ps
module pgwalk_top #(
    parameter int W        = 32,
    parameter int VA_W     = 32,
    parameter int OFF_W    = 13,
    parameter int TBL_W    = 11,
    parameter int ENT_LOG2 = 2,
    parameter int PRES_BIT = 0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    output logic            req_ready,
    input  logic [VA_W-1:0] req_vaddr,
    input  logic [W-1:0]    dir_base,
    output logic            mem_rd_valid,
    input  logic            mem_rd_ready,
    output logic [W-1:0]    mem_rd_addr,
    input  logic            mem_rsp_valid,
    input  logic [W-1:0]    mem_rsp_data,
    output logic            resp_valid,
    input  logic            resp_ready,
    output logic [W-1:0]    resp_paddr,
    output logic            resp_fault
);
    localparam int FRM_W = W - OFF_W;

    logic             ent_present;
    logic [FRM_W-1:0] ent_frame;
    logic             rd_second;
    logic             fault_q;
    logic [VA_W-1:0]  va_q;
    logic [W-1:0]     dbase_q;
    logic [FRM_W-1:0] frame_q;
    logic [W-1:0]     dir_addr;
    logic [W-1:0]     tbl_addr;

    pgwalk_entry_dec #(.W(W), .OFF_W(OFF_W), .PRES_BIT(PRES_BIT)) u_dec (
        .entry   (mem_rsp_data),
        .present (ent_present),
        .frame   (ent_frame)
    );

    pgwalk_fsm #(.W(W), .VA_W(VA_W), .OFF_W(OFF_W)) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .req_vaddr     (req_vaddr),
        .dir_base      (dir_base),
        .mem_rd_ready  (mem_rd_ready),
        .mem_rsp_valid (mem_rsp_valid),
        .ent_present   (ent_present),
        .ent_frame     (ent_frame),
        .resp_ready    (resp_ready),
        .req_ready     (req_ready),
        .mem_rd_valid  (mem_rd_valid),
        .rd_second     (rd_second),
        .resp_valid    (resp_valid),
        .fault_q       (fault_q),
        .va_q          (va_q),
        .dbase_q       (dbase_q),
        .frame_q       (frame_q)
    );

    pgwalk_addr_gen #(
        .W(W), .VA_W(VA_W), .OFF_W(OFF_W), .TBL_W(TBL_W), .ENT_LOG2(ENT_LOG2)
    ) u_addr (
        .vaddr     (va_q),
        .dir_base  (dbase_q),
        .tbl_frame (frame_q),
        .dir_addr  (dir_addr),
        .tbl_addr  (tbl_addr)
    );

    assign mem_rd_addr = rd_second ? tbl_addr : dir_addr;
    assign resp_fault  = fault_q;
    assign resp_paddr  = fault_q ? '0 : {frame_q, va_q[OFF_W-1:0]};
endmodule

// File: rtl/pgwalk_checker.sv
`timescale 1ns/1ps
module pgwalk_checker #(
    parameter int W     = 32,
    parameter int OFF_W = 13
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_ready,
    input logic [OFF_W-1:0] req_off,
    input logic             mem_rd_valid,
    input logic             mem_rd_ready,
    input logic [W-1:0]     mem_rd_addr,
    input logic             mem_rsp_valid,
    input logic             resp_valid,
    input logic             resp_ready,
    input logic [W-1:0]     resp_paddr,
    input logic             resp_fault
);
    logic             outst;
    logic [1:0]       nreads;
    logic [OFF_W-1:0] off_cap;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            outst   <= 1'b0;
            nreads  <= '0;
            off_cap <= '0;
        end else begin
            if (mem_rd_valid && mem_rd_ready) outst <= 1'b1;
            else if (mem_rsp_valid)           outst <= 1'b0;
            if (req_valid && req_ready) begin
                nreads  <= '0;
                off_cap <= req_off;
            end else if (mem_rd_valid && mem_rd_ready && nreads != 2'd3) begin
                nreads <= nreads + 2'd1;
            end
        end
    end

    assert_rd_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_valid && !mem_rd_ready) |=> (mem_rd_valid && $stable(mem_rd_addr)));

    assert_resp_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && !resp_ready) |=>
            (resp_valid && $stable(resp_paddr) && $stable(resp_fault)));

    assert_single_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_valid |-> !outst);

    assert_idle_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!mem_rd_valid && !resp_valid && !outst));

    assert_fault_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_fault) |-> (resp_paddr == '0));

    assert_offset_pass_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && !resp_fault) |-> (resp_paddr[OFF_W-1:0] == off_cap));

    assert_two_reads_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && !resp_fault) |-> (nreads == 2'd2));

    assert_some_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> (nreads != 2'd0));
endmodule

bind pgwalk_top pgwalk_checker #(.W(W), .OFF_W(OFF_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_off       (req_vaddr[OFF_W-1:0]),
    .mem_rd_valid  (mem_rd_valid),
    .mem_rd_ready  (mem_rd_ready),
    .mem_rd_addr   (mem_rd_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .resp_valid    (resp_valid),
    .resp_ready    (resp_ready),
    .resp_paddr    (resp_paddr),
    .resp_fault    (resp_fault)
);

// File: tb/pgwalk_top_test.sv
`timescale 1ns/1ps
module pgwalk_top_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic [31:0] dir_base = '0;
    logic        mem_rd_valid;
    logic        mem_rd_ready;
    logic [31:0] mem_rd_addr;
    logic        mem_rsp_valid;
    logic [31:0] mem_rsp_data;
    logic        resp_valid;
    logic        resp_ready;
    logic [31:0] resp_paddr;
    logic        resp_fault;

    always #2 clk = ~clk;

    pgwalk_top uut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr), .dir_base(dir_base),
        .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready), .mem_rd_addr(mem_rd_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .resp_valid(resp_valid), .resp_ready(resp_ready),
        .resp_paddr(resp_paddr), .resp_fault(resp_fault)
    );

    typedef struct {
        logic [31:0] paddr;
        logic        fault;
        int          nrd;
        string       tag;
    } exp_t;

    exp_t        sb[$];
    logic [31:0] mem [logic [31:0]];
    int checks = 0, fails = 0;
    int stall_cfg = 0, lat_cfg = 0, hold_cfg = 0, reads = 0;
    bit finished = 1'b0;

    localparam logic [31:0] BASE_A = 32'h0010_0000;
    localparam logic [31:0] BASE_B = 32'h0080_0000;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] rdm(input logic [31:0] a);
        if (mem.exists(a)) return mem[a];
        return 32'h0;
    endfunction

    // Independent model of the walk, built from R2..R6.
    function automatic void model(input logic [31:0] base, input logic [31:0] va,
                                  output logic [31:0] pa, output logic flt, output int nrd);
        logic [31:0] d, t;
        d = rdm(base + {22'd0, va[31:24], 2'b00});
        if (!d[0]) begin pa = '0; flt = 1'b1; nrd = 1; return; end
        t = rdm({d[31:13], 13'd0} + {19'd0, va[23:13], 2'b00});
        nrd = 2;
        if (!t[0]) begin pa = '0; flt = 1'b1; end
        else       begin pa = {t[31:13], va[12:0]}; flt = 1'b0; end
    endfunction

    task automatic walk(input logic [31:0] base, input logic [31:0] va, input string tag,
                        input bit swap, input bit poke);
        exp_t e;
        model(base, va, e.paddr, e.fault, e.nrd);
        e.tag = tag;
        sb.push_back(e);
        req_vaddr = va;
        dir_base  = base;
        req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        check(req_ready == 1'b0, "R7 not ready while walking", {31'd0, req_ready}, 32'd0);
        if (swap) dir_base = ~base ^ 32'h5a5a_0000;   // R11: must not matter
        if (poke) begin                               // R7: ignored while busy
            req_vaddr = ~va;
            req_valid = 1'b1;
            @(negedge clk);
            req_valid = 1'b0;
            req_vaddr = va;
        end
    endtask

    task automatic wait_idle();
        while (sb.size() != 0 || !req_ready) @(negedge clk);
    endtask

    // Memory responder.
    initial begin
        int   ph = 0, wc = 0;
        logic [31:0] cur = '0;
        mem_rd_ready  = 1'b0;
        mem_rsp_valid = 1'b0;
        mem_rsp_data  = '0;
        forever begin
            @(negedge clk);
            mem_rd_ready  = 1'b0;
            mem_rsp_valid = 1'b0;
            if (ph == 0) begin
                if (mem_rd_valid) begin
                    if (wc < stall_cfg) wc++;
                    else begin
                        mem_rd_ready = 1'b1;
                        cur = mem_rd_addr;
                        reads++;
                        ph = 1; wc = 0;
                    end
                end
            end else begin
                if (wc < lat_cfg) wc++;
                else begin
                    mem_rsp_valid = 1'b1;
                    mem_rsp_data  = rdm(cur);
                    ph = 0; wc = 0;
                end
            end
        end
    end

    // Result monitor / scoreboard.
    initial begin
        resp_ready = 1'b0;
        forever begin
            @(negedge clk);
            if (resp_valid) begin
                if (sb.size() == 0) begin
                    check(1'b0, "R7 result without accepted request", resp_paddr, 32'd0);
                end else begin
                    exp_t        e;
                    logic [31:0] held;
                    e = sb.pop_front();
                    check(resp_fault == e.fault, {e.tag, " fault flag"}, {31'd0, resp_fault}, {31'd0, e.fault});
                    check(resp_paddr == e.paddr, {e.tag, " paddr"}, resp_paddr, e.paddr);
                    check(reads == e.nrd, {e.tag, " R12 read count"}, reads, e.nrd);
                    reads = 0;
                    held = resp_paddr;
                    for (int k = 0; k < hold_cfg; k++) begin
                        @(negedge clk);
                        check(resp_valid && resp_paddr == held, "R9 result held", resp_paddr, held);
                    end
                end
                resp_ready = 1'b1;
                @(negedge clk);
                resp_ready = 1'b0;
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] x = 32'h1357_9bdf;
        // Tables
        mem[BASE_A + 32'h340] = 32'h0020_0FFF;        // idx d0, junk low bits (R3)
        mem[32'h0020_0080]    = 32'h1234_6001;
        mem[32'h0020_0008]    = 32'h3333_2000;        // table entry not present
        mem[BASE_A + 32'h3FC] = 32'h0040_0001;        // idx ff
        mem[32'h0040_1FFC]    = 32'hFEDC_A003;
        mem[BASE_A]           = 32'h0060_0001;        // idx 00
        mem[32'h0060_0000]    = 32'h0000_2001;
        mem[BASE_A + 32'h080] = 32'h0070_0000;        // idx 20, dir not present
        mem[BASE_B + 32'h340] = 32'h00A0_0001;
        mem[32'h00A0_0080]    = 32'h7777_E001;

        repeat (3) @(negedge clk);
        check(req_ready == 1'b1, "R1 reset req_ready", {31'd0, req_ready}, 32'd1);
        check(resp_valid == 1'b0, "R1 reset resp_valid", {31'd0, resp_valid}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready == 1'b1 && resp_valid == 1'b0 && mem_rd_valid == 1'b0,
              "R1 after reset", {29'd0, req_ready, resp_valid, mem_rd_valid}, 32'd4);

        walk(BASE_A, 32'hD004_000C, "R2 R3 R4 basic", 1'b0, 1'b0);
        wait_idle();
        walk(BASE_A, 32'hFFFF_FFFF, "R2 R3 R4 top index", 1'b0, 1'b0);
        wait_idle();
        walk(BASE_A, 32'h0000_0000, "R2 R3 R4 zero index", 1'b0, 1'b0);
        wait_idle();
        walk(BASE_B, 32'hD004_000C, "R2 other base", 1'b0, 1'b0);
        wait_idle();
        walk(BASE_A, 32'h5000_1234, "R5 dir missing", 1'b0, 1'b0);
        wait_idle();
        walk(BASE_A, 32'h2000_0ABC, "R5 dir bit0 clear", 1'b0, 1'b0);
        wait_idle();
        walk(BASE_A, 32'hD000_2000, "R6 table missing", 1'b0, 1'b0);
        wait_idle();
        walk(BASE_A, 32'hD000_4010, "R6 table bit0 clear", 1'b0, 1'b0);
        wait_idle();

        stall_cfg = 2; lat_cfg = 3; hold_cfg = 2;
        walk(BASE_A, 32'hD004_1FFF, "R11 base changed after accept", 1'b1, 1'b0);
        wait_idle();
        walk(BASE_A, 32'hFFFF_E000, "R7 request while busy", 1'b0, 1'b1);
        wait_idle();
        check(resp_valid == 1'b0 && req_ready == 1'b1, "R7 no extra walk",
              {30'd0, resp_valid, req_ready}, 32'd1);

        hold_cfg = 3; stall_cfg = 1; lat_cfg = 0;
        walk(BASE_A, 32'hD004_0004, "R10 back-to-back a", 1'b0, 1'b0);
        walk(BASE_B, 32'hD004_0008, "R10 back-to-back b", 1'b0, 1'b0);
        walk(BASE_A, 32'h0000_1111, "R10 back-to-back c", 1'b0, 1'b0);
        wait_idle();

        for (int i = 0; i < 24; i++) begin
            logic [31:0] da, ta, de;
            x ^= x << 13; x ^= x >> 17; x ^= x << 5;
            stall_cfg = i % 3; lat_cfg = (i * 2) % 5; hold_cfg = i % 2;
            da = BASE_A + {22'd0, x[31:24], 2'b00};
            if (!mem.exists(da)) mem[da] = 32'h0100_0001 + {11'd0, x[31:24], 13'd0};
            de = mem[da];
            ta = {de[31:13], 13'd0} + {19'd0, x[23:13], 2'b00};
            if (i % 3 != 2) mem[ta] = (x * 32'h9E37_79B1) | 32'h1;
            walk(BASE_A, x, "R4 R12 random walk", 1'b0, 1'b0);
            wait_idle();
        end

        repeat (5) @(negedge clk);
        check(sb.size() == 0, "R7 all results delivered", sb.size(), 32'd0);
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule